// File: doc/BRIEF.md
# Pipelined Fixed-Point PID Control Stage

This block turns a stream of signed error samples into a stream of saturated signed control words. It takes at most one sample per clock, flagged by an input strobe, and never stalls. Three signed gain inputs set the proportional, integral and derivative weights. The gains are read in the same cycle as the sample they apply to.

The work is split over two register stages. In the first stage, three multipliers run side by side. One forms the proportional product. One updates a clamped integral accumulator. One weights the change in error since the previous valid sample. The three results are latched together. In the second stage, the latched terms are added at full width, the sum is clamped to the output range, and the result is registered.

The output strobe is the input strobe delayed by two registers, so every gap in the input stream shows up in the same position at the output. The block is meant to sit in a control loop where a fixed, data-independent response time matters more than sharing arithmetic.

Top module: `pid_pipe`

## Requirements
- R1: While the active-low reset is low, `outValid` and `outData` are 0. Reset also clears the integral accumulator and the stored previous error. After reset, with only the integral gain nonzero and zero error, the output is 0.
- R2: `outValid` is high exactly two rising edges after an edge that saw `inValid` high. It is low two edges after an edge that saw `inValid` low, so input gaps are preserved.
- R3: Samples presented on consecutive clocks each produce one valid output on consecutive clocks, in order, with no stall.
- R4: With only `gainP` nonzero, the valid output is `gainP * err` for the sample taken two edges earlier.
- R5: On each valid sample, the accumulator becomes clamp(acc + `gainI` * err). The integral contribution to that sample's output is this new accumulator value. Samples with `inValid` low leave the accumulator unchanged, whatever `errIn` holds.
- R6: The derivative contribution is `gainD` * (err − previous valid err). The previous error is loaded only on valid samples and is 0 after reset.
- R7: The output is the full-width sum of the three terms, clamped to the signed `OUT_W`-bit range. A sum above the maximum gives 2^(OUT_W−1)−1. A sum below the minimum gives −2^(OUT_W−1).
- R8: The accumulator is clamped to the signed `ACC_W`-bit range on every update. When the output is not itself saturated, a held accumulator shows at the output as exactly ±limit.
- R9: With all three gains at zero, every valid output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Error sample strobe |
| errIn | input | ERR_W | Signed error sample |
| gainP | input | GAIN_W | Signed proportional gain |
| gainI | input | GAIN_W | Signed integral gain |
| gainD | input | GAIN_W | Signed derivative gain |
| outValid | output | 1 | Control word strobe |
| outData | output | OUT_W | Saturated signed control word |

## Verification
Every sample's result is due exactly two rising edges after the edge that captured it. The integral and previous-error state change on that first edge.

The bench drives inputs on falling edges and updates its reference model on each rising edge. It compares `outValid`, and `outData` whenever the model expects valid, on the following falling edge. A result is therefore checked in the cycle it must appear, and never a cycle early or late.

Each scenario ends with two idle steps, so its final samples are checked before the next scenario changes gains or resets.

// File: rtl/pid_pkg.sv
package pid_pkg;
  // strobes from the control path to the datapath
  typedef struct packed {
    logic loadTerms;   // stage-one registers and state capture a sample
    logic loadSum;     // stage-two register captures the clamped sum
  } pid_strobe_t;
endpackage

// File: rtl/pid_clamp.sv
module pid_clamp #(
  parameter int IN_W  = 36,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam logic signed [IN_W-1:0] HiLim = {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] LoLim = {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  always_comb begin
    if (din > HiLim)      dout = HiLim[OUT_W-1:0];
    else if (din < LoLim) dout = LoLim[OUT_W-1:0];
    else                  dout = din[OUT_W-1:0];
  end
endmodule

// File: rtl/pid_ctrl.sv
module pid_ctrl
  import pid_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output pid_strobe_t strobe,
  output logic        outValid
);
  logic stage1Valid;
  logic stage2Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      stage2Valid <= stage1Valid;
    end
  end

  always_comb begin
    strobe.loadTerms = inValid;
    strobe.loadSum   = stage1Valid;
  end

  assign outValid = stage2Valid;
endmodule

// File: rtl/pid_datapath.sv
module pid_datapath
  import pid_pkg::*;
#(
  parameter int ERR_W  = 16,
  parameter int GAIN_W = 16,
  parameter int ACC_W  = 32,
  parameter int OUT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pid_strobe_t              strobe,
  input  logic signed [ERR_W-1:0]  errIn,
  input  logic signed [GAIN_W-1:0] gainP,
  input  logic signed [GAIN_W-1:0] gainI,
  input  logic signed [GAIN_W-1:0] gainD,
  output logic signed [OUT_W-1:0]  outData,
  output logic signed [ACC_W-1:0]  accVal,
  output logic signed [ERR_W-1:0]  prevErrVal
);
  localparam int ProdW  = ERR_W + GAIN_W;
  localparam int DiffW  = ERR_W + 1;
  localparam int DProdW = DiffW + GAIN_W;
  localparam int AccSumW = ((ACC_W > ProdW) ? ACC_W : ProdW) + 1;
  localparam int SumW   = ((ACC_W > DProdW) ? ACC_W : DProdW) + 2;

  // state and stage-one registers
  logic signed [ACC_W-1:0]  accQ;
  logic signed [ERR_W-1:0]  prevErrQ;
  logic signed [ProdW-1:0]  pTermQ;
  logic signed [ACC_W-1:0]  iTermQ;
  logic signed [DProdW-1:0] dTermQ;
  logic signed [OUT_W-1:0]  outQ;

  // stage one: three parallel multiplies
  logic signed [ProdW-1:0]   pProd;
  logic signed [ProdW-1:0]   iProd;
  logic signed [DiffW-1:0]   errDiff;
  logic signed [DProdW-1:0]  dProd;
  logic signed [AccSumW-1:0] accSum;
  logic signed [ACC_W-1:0]   accNext;

  assign pProd   = ProdW'(gainP) * ProdW'(errIn);
  assign iProd   = ProdW'(gainI) * ProdW'(errIn);
  assign errDiff = DiffW'(errIn) - DiffW'(prevErrQ);
  assign dProd   = DProdW'(gainD) * DProdW'(errDiff);
  assign accSum  = AccSumW'(accQ) + AccSumW'(iProd);

  pid_clamp #(.IN_W(AccSumW), .OUT_W(ACC_W)) i_accClamp (
    .din  (accSum),
    .dout (accNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ     <= '0;
      prevErrQ <= '0;
      pTermQ   <= '0;
      iTermQ   <= '0;
      dTermQ   <= '0;
    end else if (strobe.loadTerms) begin
      accQ     <= accNext;
      prevErrQ <= errIn;
      pTermQ   <= pProd;
      iTermQ   <= accNext;
      dTermQ   <= dProd;
    end
  end

  // stage two: add tree and saturation
  logic signed [SumW-1:0]  termSum;
  logic signed [OUT_W-1:0] sumClamped;

  assign termSum = SumW'(pTermQ) + SumW'(iTermQ) + SumW'(dTermQ);

  pid_clamp #(.IN_W(SumW), .OUT_W(OUT_W)) i_outClamp (
    .din  (termSum),
    .dout (sumClamped)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               outQ <= '0;
    else if (strobe.loadSum) outQ <= sumClamped;
  end

  assign outData    = outQ;
  assign accVal     = accQ;
  assign prevErrVal = prevErrQ;
endmodule

// File: rtl/pid_pipe.sv
module pid_pipe
  import pid_pkg::*;
#(
  parameter int ERR_W  = 16,
  parameter int GAIN_W = 16,
  parameter int ACC_W  = 32,
  parameter int OUT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [ERR_W-1:0]  errIn,
  input  logic signed [GAIN_W-1:0] gainP,
  input  logic signed [GAIN_W-1:0] gainI,
  input  logic signed [GAIN_W-1:0] gainD,
  output logic                     outValid,
  output logic signed [OUT_W-1:0]  outData
);
  pid_strobe_t             strobe;
  logic signed [ACC_W-1:0] accVal;
  logic signed [ERR_W-1:0] prevErrVal;

  pid_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  pid_datapath #(
    .ERR_W  (ERR_W),
    .GAIN_W (GAIN_W),
    .ACC_W  (ACC_W),
    .OUT_W  (OUT_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .errIn      (errIn),
    .gainP      (gainP),
    .gainI      (gainI),
    .gainD      (gainD),
    .outData    (outData),
    .accVal     (accVal),
    .prevErrVal (prevErrVal)
  );
endmodule

// File: rtl/pid_pipe_chk.sv
module pid_pipe_chk #(
  parameter int ERR_W = 16,
  parameter int ACC_W = 32
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic signed [ERR_W-1:0] errIn,
  input logic                    outValid,
  input logic signed [ACC_W-1:0] accVal,
  input logic signed [ERR_W-1:0] prevErrVal
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R1: reset holds the output strobe low
  p_reset_quiet_r1: assert property (@(posedge clk) !rstN |-> !outValid);

  // R2: output strobe is input strobe two edges later
  p_latency_two_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 2)));

  // R5: accumulator holds across gaps
  p_acc_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && !$past(inValid)) |-> $stable(accVal));

  // R6: previous error holds across gaps and loads on valid samples
  p_prev_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && !$past(inValid)) |-> $stable(prevErrVal));

  p_prev_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (prevErrVal == $past(errIn)));
endmodule

bind pid_pipe pid_pipe_chk #(.ERR_W(ERR_W), .ACC_W(ACC_W)) i_pidChk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .errIn      (errIn),
  .outValid   (outValid),
  .accVal     (accVal),
  .prevErrVal (prevErrVal)
);

// File: tb/test_pid_pipe.sv
module test_pid_pipe;
  localparam int ERR_W  = 16;
  localparam int GAIN_W = 16;
  localparam int ACC_W  = 24;
  localparam int OUT_W  = 28;
  localparam time CLK_HALF = 10ns;

  logic                     clk = 1'b0;
  logic                     rstN = 1'b1;
  logic                     inValid = 1'b0;
  logic signed [ERR_W-1:0]  errIn = '0;
  logic signed [GAIN_W-1:0] gainP = '0;
  logic signed [GAIN_W-1:0] gainI = '0;
  logic signed [GAIN_W-1:0] gainD = '0;
  logic                     outValid;
  logic signed [OUT_W-1:0]  outData;

  pid_pipe #(.ERR_W(ERR_W), .GAIN_W(GAIN_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) i_pid_pipe (
    .clk(clk), .rstN(rstN), .inValid(inValid), .errIn(errIn),
    .gainP(gainP), .gainI(gainI), .gainD(gainD),
    .outValid(outValid), .outData(outData)
  );

  always #(CLK_HALF) clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // reference model state
  longint mAcc = 0, mPrev = 0, mS1Sum = 0, mOut = 0;
  bit     mS1V = 1'b0, mOutV = 1'b0;

  function automatic longint clampTo(longint x, int w);
    longint hi = (longint'(1) <<< (w - 1)) - 1;
    longint lo = -(longint'(1) <<< (w - 1));
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction

  task automatic check(string tag, longint act, longint exp, string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic setGains(longint p, longint i, longint d);
    gainP = GAIN_W'(p);
    gainI = GAIN_W'(i);
    gainD = GAIN_W'(d);
  endtask

  // check outputs due now, drive one sample, advance one clock
  task automatic step(bit v, longint e, string tag);
    check(tag, longint'(outValid), longint'(mOutV), "outValid");
    if (mOutV) check(tag, longint'(outData), mOut, "outData");
    inValid = v;
    errIn   = ERR_W'(e);
    @(posedge clk);
    if (mS1V) mOut = mS1Sum;
    mOutV = mS1V;
    mS1V  = v;
    if (v) begin
      mAcc   = clampTo(mAcc + longint'(gainI) * e, ACC_W);
      mS1Sum = clampTo(longint'(gainP) * e + mAcc + longint'(gainD) * (e - mPrev), OUT_W);
      mPrev  = e;
    end
    @(negedge clk);
  endtask

  task automatic drain(string tag);
    step(1'b0, 0, tag);
    step(1'b0, 0, tag);
  endtask

  task automatic doReset(string tag);
    inValid = 1'b0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    // R1: outputs cleared while in reset
    check(tag, longint'(outValid), 0, "outValid in reset");
    check(tag, longint'(outData), 0, "outData in reset");
    rstN = 1'b1;
    mAcc = 0; mPrev = 0; mS1Sum = 0; mOut = 0; mS1V = 1'b0; mOutV = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();          // R1
    doReset("R1");
    step(1'b0, 0, "R1");
  endtask

  task automatic testZeroGains();      // R9
    setGains(0, 0, 0);
    step(1'b1, 1234, "R9");
    step(1'b1, -32768, "R9");
    step(1'b1, 32767, "R9");
    step(1'b1, -7, "R9");
    drain("R9");
  endtask

  task automatic testProportional();   // R4
    setGains(3, 0, 0);
    repeat (5) step(1'b1, -1200, "R4");
    drain("R4");
  endtask

  task automatic testBubbles();        // R2
    setGains(2, 0, 0);
    step(1'b1, 10, "R2");
    step(1'b0, 99, "R2");
    step(1'b1, 20, "R2");
    step(1'b1, 30, "R2");
    step(1'b0, 0, "R2");
    step(1'b0, 0, "R2");
    step(1'b1, 40, "R2");
    drain("R2");
  endtask

  task automatic testThroughput();     // R3
    setGains(-7, 0, 0);
    for (int k = 0; k < 8; k++) step(1'b1, 100 * k - 350, "R3");
    drain("R3");
  endtask

  task automatic testIntegral();       // R5
    doReset("R5");
    setGains(0, 2, 0);
    step(1'b1, 10, "R5");
    step(1'b0, 999, "R5");
    step(1'b1, 10, "R5");
    step(1'b0, -5000, "R5");
    step(1'b1, -3, "R5");
    drain("R5");
  endtask

  task automatic testDerivative();     // R6
    doReset("R6");
    setGains(0, 0, 5);
    step(1'b1, 100, "R6");
    step(1'b0, 7000, "R6");
    step(1'b1, 130, "R6");
    step(1'b1, 90, "R6");
    step(1'b1, 90, "R6");
    drain("R6");
  endtask

  task automatic testOutSat();         // R7
    doReset("R7");
    setGains(32767, 0, 0);
    step(1'b1, 32767, "R7");
    step(1'b1, -32768, "R7");
    step(1'b1, 5, "R7");
    drain("R7");
  endtask

  task automatic testAccClamp();       // R8
    doReset("R8");
    setGains(0, 1000, 0);
    for (int k = 0; k < 10; k++) step(1'b1, 1000, "R8");
    step(1'b1, 0, "R8");
    step(1'b1, 0, "R8");
    for (int k = 0; k < 20; k++) step(1'b1, -1000, "R8");
    step(1'b1, 0, "R8");
    drain("R8");
  endtask

  task automatic testResetClears();    // R1
    setGains(1, 50, 1);
    step(1'b1, 300, "R1");
    step(1'b1, 300, "R1");
    doReset("R1");
    setGains(0, 50, 0);
    step(1'b1, 0, "R1");
    drain("R1");
  endtask

  initial begin
    #2 rstN = 1'b0;
    @(negedge clk);
    testReset();
    testZeroGains();
    testProportional();
    testBubbles();
    testThroughput();
    testIntegral();
    testDerivative();
    testOutSat();
    testAccClamp();
    testResetClears();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule